// File: doc/BRIEF.md
# Level Interrupt Cause and Mask Unit

This unit gathers seven level interrupt sources into a sticky cause register. While a source input is high, its cause bit is set. A per-source enable register selects which cause bits count as pending. The OR of the pending bits drives a single summary interrupt line, registered by one cycle. A read-only lookup word gives the number of the highest pending source, so a handler can service sources from the top down without scanning the register itself.

Both registers are plain read/write. A write stores exactly the value given, so writing a 1 sets a cause bit. To acknowledge a source, software reads the cause register, clears the bits it has handled, and writes the result back. If a source fires in the same cycle as that write, the hardware set takes priority, so the new event is not lost.

Top module: `irq_cause_unit`

## Requirements
- R1: After reset, the cause register reads 0, the enable register reads 0, the lookup word reads 0 and `irq_o` is 0.
- R2: Address 1 is the enable register. It takes the written value on bits 6:0, and bits 31:7 always read 0.
- R3: Address 0 is the cause register. Each bit takes exactly the written value, so writing 1 sets it and writing 0 clears it. Bits 31:7 read 0.
- R4: A source input that is high at a clock edge sets its cause bit from that edge on. The bit stays set after the source falls, until software writes it to 0.
- R5: When a source is high in the same cycle as a cause write, that cause bit ends up 1, whatever value was written.
- R6: A source is pending when both its cause bit and its enable bit are 1. `irq_o` is the OR of all pending bits, delayed by one clock cycle.
- R7: Address 2 is a read-only lookup word. Bits 2:0 hold the highest-numbered pending source and bit 8 is a valid flag. When nothing is pending, the whole word reads 0.
- R8: A write to address 2 or address 3 changes neither the cause register nor the enable register.
- R9: Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 7 | Level interrupt sources, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 cause, 1 enable, 2 lookup, 3 spare |
| reg_wdata | input | 7 | Write data, one bit per source |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Registered summary interrupt |

## Verification
The hardest case to reach is a source firing in the very cycle in which software writes back a cleared cause value. From the ports alone, this looks like a lost acknowledgement. The bench lines the two up by driving the source and the write strobe on the same falling edge. It then reads the cause word after the next rising edge. It also runs a full read, clear and write-back acknowledge and checks that only the handled bit falls.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
   typedef enum logic [1:0] {
      SEL_CAUSE  = 2'd0,
      SEL_ENABLE = 2'd1,
      SEL_LOOKUP = 2'd2,
      SEL_SPARE  = 2'd3
   } reg_sel_e;

   localparam int LOOKUP_VALID_POS = 8;
endpackage

// File: rtl/irq_cause_store.sv
module irq_cause_store #(
   parameter int NUM_SRC = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               cause_we,
   input  logic               enable_we,
   input  logic [NUM_SRC-1:0] wdata,
   output logic [NUM_SRC-1:0] cause_q,
   output logic [NUM_SRC-1:0] enable_q
);
   generate
      if (NUM_SRC < 1) begin : g_bad_cnt
         $error("irq_cause_store: NUM_SRC must be at least 1");
      end
   endgenerate

   // one sticky flop per source; a hardware set overrides the written value
   generate
      for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cause_q[b] <= 1'b0;
            end else if (src_i[b]) begin
               cause_q[b] <= 1'b1;
            end else if (cause_we) begin
               cause_q[b] <= wdata[b];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_q <= '0;
      end else if (enable_we) begin
         enable_q <= wdata;
      end
   end

   // R2
   enable_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enable_we |=> enable_q == $past(wdata));

   // R4
   src_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      |src_i |=> (cause_q & $past(src_i)) == $past(src_i));

   // R3
   cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cause_we && src_i == '0) |=> $stable(cause_q));
endmodule

// File: rtl/irq_hi_enc.sv
module irq_hi_enc #(
   parameter int N  = 7,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic [IW-1:0] idx,
   output logic          valid
);
   // later (higher) indices override earlier ones
   always_comb begin
      idx   = '0;
      valid = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (req[i]) begin
            idx   = IW'(i);
            valid = 1'b1;
         end
      end
   end
endmodule

// File: rtl/irq_sum_out.sv
module irq_sum_out #(
   parameter bit REGISTERED = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic any_pend,
   output logic irq_o
);
   generate
      if (REGISTERED) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_o <= 1'b0;
            else        irq_o <= any_pend;
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign irq_o = any_pend;
      end
   endgenerate
endmodule

// File: rtl/irq_cause_unit.sv
module irq_cause_unit
   import irq_cause_pkg::*;
#(
   parameter int NUM_SRC = 7,
   parameter int DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               reg_we,
   input  logic [1:0]         reg_addr,
   input  logic [NUM_SRC-1:0] reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic               irq_o
);
   localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

   generate
      if (NUM_SRC > DATA_W) begin : g_bad_w
         $error("irq_cause_unit: NUM_SRC exceeds DATA_W");
      end
      if (IDX_W > LOOKUP_VALID_POS || LOOKUP_VALID_POS >= DATA_W) begin : g_bad_pos
         $error("irq_cause_unit: lookup fields do not fit");
      end
   endgenerate

   reg_sel_e           sel;
   logic [NUM_SRC-1:0] cause_q, enable_q, pend;
   logic [IDX_W-1:0]   hi_idx;
   logic               hi_valid;

   assign sel = reg_sel_e'(reg_addr);

   irq_cause_store #(.NUM_SRC(NUM_SRC)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_i     (src_i),
      .cause_we  (reg_we && sel == SEL_CAUSE),
      .enable_we (reg_we && sel == SEL_ENABLE),
      .wdata     (reg_wdata),
      .cause_q   (cause_q),
      .enable_q  (enable_q)
   );

   assign pend = cause_q & enable_q;

   irq_hi_enc #(.N(NUM_SRC), .IW(IDX_W)) u_enc (
      .req   (pend),
      .idx   (hi_idx),
      .valid (hi_valid)
   );

   irq_sum_out #(.REGISTERED(1'b1)) u_sum (
      .clk      (clk),
      .rst_n    (rst_n),
      .any_pend (|pend),
      .irq_o    (irq_o)
   );

   always_comb begin
      reg_rdata = '0;
      unique case (sel)
         SEL_CAUSE:  reg_rdata[NUM_SRC-1:0] = cause_q;
         SEL_ENABLE: reg_rdata[NUM_SRC-1:0] = enable_q;
         SEL_LOOKUP: begin
            reg_rdata[IDX_W-1:0]       = hi_idx;
            reg_rdata[LOOKUP_VALID_POS] = hi_valid;
         end
         SEL_SPARE:  reg_rdata = '0;
      endcase
   end

   // R6
   irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> irq_o == $past(hi_valid));

   // R7
   lookup_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hi_valid |-> (cause_q[hi_idx] && enable_q[hi_idx]));

   // R7
   lookup_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hi_valid |-> ((pend >> hi_idx) == NUM_SRC'(1)));

   // R8
   spare_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr[1] && src_i == '0) |=> ($stable(cause_q) && $stable(enable_q)));
endmodule

// File: tb/tb_irq_cause_unit.sv
module tb_irq_cause_unit;
   localparam time CLK_PER = 10ns;
   localparam int  WDOG_CYC = 5000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  src_i = '0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [6:0]  reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PER/2) clk = ~clk;

   irq_cause_unit dut (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_o(irq_o)
   );

   // {enable[7:0], cause[7:0], expected lookup word[15:0]}
   localparam logic [31:0] VEC [7] = '{
      32'h7F00_0000, 32'h7F01_0100, 32'h7F40_0106, 32'h7F55_0106,
      32'h0F55_0102, 32'h2A55_0000, 32'h7F18_0104
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [6:0] d);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(posedge clk); @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      reg_addr = a; #1; d = reg_rdata;
   endtask

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      // R1 reset values
      rd(2'd0, v); check("R1 cause", v, 32'h0);
      rd(2'd1, v); check("R1 enable", v, 32'h0);
      rd(2'd2, v); check("R1 lookup", v, 32'h0);
      check("R1 irq", {31'b0, irq_o}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk: R6 R7
      for (int k = 0; k < 7; k++) begin
         wr(2'd1, VEC[k][30:24]);
         wr(2'd0, VEC[k][22:16]);
         rd(2'd2, v); check("R7 lookup table", v, {16'h0, VEC[k][15:0]});
         @(negedge clk);
         check("R6 irq table", {31'b0, irq_o}, {31'b0, VEC[k][8]});
      end

      // R2
      wr(2'd1, 7'h7F); rd(2'd1, v); check("R2 enable all", v, 32'h7F);
      wr(2'd1, 7'h25); rd(2'd1, v); check("R2 enable pattern", v, 32'h25);
      // R3
      wr(2'd0, 7'h2A); rd(2'd0, v); check("R3 cause set by write", v, 32'h2A);
      wr(2'd0, 7'h00); rd(2'd0, v); check("R3 cause clear by write", v, 32'h0);
      // R4 single-cycle pulse stays sticky
      src_i = 7'h08; @(posedge clk); @(negedge clk); src_i = '0;
      @(negedge clk);
      rd(2'd0, v); check("R4 sticky cause", v, 32'h08);
      // R5 source wins over write of 0
      wr(2'd0, 7'h10);
      src_i = 7'h01; wr(2'd0, 7'h00); src_i = '0;
      rd(2'd0, v); check("R5 event beats write", v, 32'h01);
      // R3 read-clear-writeback acknowledge
      wr(2'd0, 7'h41);
      rd(2'd0, v);
      wr(2'd0, v[6:0] & ~7'h40);
      rd(2'd0, v); check("R3 acknowledge", v, 32'h01);
      // R8 writes to lookup and spare
      wr(2'd1, 7'h33);
      wr(2'd2, 7'h7F); wr(2'd3, 7'h7F);
      rd(2'd0, v); check("R8 cause untouched", v, 32'h01);
      rd(2'd1, v); check("R8 enable untouched", v, 32'h33);
      // R9
      rd(2'd3, v); check("R9 spare reads zero", v, 32'h0);
      // R6 one-cycle delay of irq
      wr(2'd1, 7'h00); wr(2'd0, 7'h04);
      @(negedge clk);
      check("R6 masked no irq", {31'b0, irq_o}, 32'h0);
      wr(2'd1, 7'h04);
      check("R6 irq still low", {31'b0, irq_o}, 32'h0);
      rd(2'd2, v); check("R7 lookup single", v, 32'h102);
      @(negedge clk);
      check("R6 irq raised", {31'b0, irq_o}, 32'h1);
      wr(2'd0, 7'h00);
      rd(2'd2, v); check("R7 lookup empty", v, 32'h0);
      @(negedge clk);
      check("R6 irq dropped", {31'b0, irq_o}, 32'h0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (WDOG_CYC) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule